// File: doc/BRIEF.md
# Word/Byte Arithmetic-Logic Unit with Packed-Decimal Add

This block is the arithmetic-logic unit of a 16-bit two-operand register machine. Each operation takes a source operand, a destination operand and the current carry, negative, zero and overflow flags. It returns a result, a write-enable for that result and the four updated flags. The operations are binary add and subtract, each with and without carry, compare, the logical operations, packed-BCD decimal add, two right shifts, byte swap and sign extension. Every arithmetic and logical operation can run on the whole word or on the low byte only.

Subtraction is done as destination plus the inverted source plus a carry-in. A set carry after a subtract therefore means that no borrow occurred. The datapath is combinational. A single output register, together with a valid strobe, presents each result one clock after its operands are applied. Register file, operand fetch, addressing and instruction decode live outside the block.

Top module: `wcalc_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `out_valid`, `wr_en`, `result` and all four flags at zero.
- R2: The output stage captures each operation on the edge where `in_valid` is high. `out_valid` is high in the following cycle only. The `op` codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 AND, 6 bit-clear, 7 bit-set, 8 bit-test, 9 XOR, 10 decimal add, 11 arithmetic shift right, 12 rotate right through carry, 13 byte swap, 14 sign extend.
- R3: Add gives dst+src, and add-with-carry gives dst+src+c_in. The carry is the carry out of the top bit. Overflow is set when both operands have the same sign and the result's sign differs from it.
- R4: Subtract gives dst+NOT(src)+1, and subtract-with-carry gives dst+NOT(src)+c_in. The carry is set when no borrow occurs. Overflow is set when the operands differ in sign and the result's sign differs from dst's sign.
- R5: Compare sets flags exactly as subtract does. Bit-test sets flags exactly as AND does. Both drive `wr_en` low. Every other code drives it high.
- R6: AND (src&dst) and XOR (src^dst) set carry to NOT zero and clear overflow.
- R7: Bit-clear gives NOT(src)&dst and bit-set gives src|dst. Both copy `c_in`, `z_in`, `n_in` and `v_in` unchanged to the outputs.
- R8: Decimal add gives src+dst+c_in in packed BCD, with 4 digits in word mode and 2 digits in byte mode. The carry is the decimal carry out of the top digit, and overflow is cleared.
- R9: Arithmetic shift right acts on dst. It keeps the top bit, moves every other bit down one place and puts the old bit 0 into carry. Overflow is cleared.
- R10: Rotate right through carry acts on dst. It puts `c_in` into the top bit and the old bit 0 into carry. Overflow is cleared.
- R11: Byte swap and sign extend act on all 16 bits of dst and ignore `byte_mode`. Byte swap exchanges the two bytes and passes all flags through. Sign extend copies bit 7 into bits 8..15, takes N and Z from the 16-bit result, sets C to NOT Z and clears V.
- R12: With `byte_mode`=1, every other operation uses bits 7..0 only. It takes its flags from bit 7 and the low byte, and returns 0 in result bits 15..8.
- R13: Except where flags pass through, Z is set exactly when the (width-limited) result is zero. N equals the result's top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and code valid this cycle |
| op | input | 4 | Operation code (see R2) |
| byte_mode | input | 1 | 1 = low-byte operation |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| c_in | input | 1 | Incoming carry |
| z_in | input | 1 | Incoming zero flag |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Registered result valid |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Result should be written back |
| c_out | output | 1 | Carry flag |
| z_out | output | 1 | Zero flag |
| n_out | output | 1 | Negative flag |
| v_out | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default width of 16 bits, which gives 2 byte-mode digits and 4 word-mode digits for the decimal adder. At this width, both carry positions, bit 7 and bit 15, can be reached with hand-picked vectors. These include signed overflow in both directions, borrow and no-borrow subtraction, decimal carry out of digit 1 and digit 3, and the sign-extend and byte-swap cases that ignore the byte select. Random word and byte vectors across every code then exercise the result, write-enable and flags against a reference model written from the requirements.

// File: rtl/wcalc_pkg.sv
// Shared operation codes and flag bundle for the word/byte ALU.
// Assumes a 4-bit operation code; unused codes are treated as no-ops.
package wcalc_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_BIC  = 4'd6,
        OP_BIS  = 4'd7,
        OP_BIT  = 4'd8,
        OP_XOR  = 4'd9,
        OP_DADD = 4'd10,
        OP_RRA  = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWPB = 4'd13,
        OP_SXT  = 4'd14,
        OP_NONE = 4'd15
    } calc_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } calc_flags_t;
endpackage

// File: rtl/wcalc_binadd.sv
// Binary adder with byte/word carry and signed-overflow selection.
// Assumes the caller has already inverted the first operand for subtraction,
// so one overflow rule covers both directions.
module wcalc_binadd #(
    parameter int W = 16
) (
    input  logic         byte_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int H = W / 2;

    logic [W:0] full_s;
    logic [H:0] half_s;
    logic       sa, sb, sr;

    // Both widths are summed in parallel; byte_mode picks one.
    always_comb begin
        full_s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        half_s = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        if (byte_mode) begin
            sum  = {{(W-H){1'b0}}, half_s[H-1:0]};
            cout = half_s[H];
            sa   = a[H-1];
            sb   = b[H-1];
            sr   = half_s[H-1];
        end else begin
            sum  = full_s[W-1:0];
            cout = full_s[W];
            sa   = a[W-1];
            sb   = b[W-1];
            sr   = full_s[W-1];
        end
        ovf = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/wcalc_bcdadd.sv
// Packed-BCD ripple adder, one generated stage per decimal digit.
// Assumes both operands hold valid BCD digits; the byte form stops at digit 1.
module wcalc_bcdadd #(
    parameter int W = 16
) (
    input  logic         byte_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int DIG   = W / 4;
    localparam int HDIG  = DIG / 2;
    localparam int H     = W / 2;

    logic [DIG:0]   cy;
    logic [W-1:0]   raw_sum;

    assign cy[0] = cin;

    for (genvar i = 0; i < DIG; i++) begin : g_digit
        logic [4:0] bin;
        logic       adj;
        // Binary digit sum, then +6 correction when it exceeds nine.
        always_comb begin
            bin = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, cy[i]};
            adj = (bin > 5'd9);
            raw_sum[4*i +: 4] = adj ? (bin[3:0] + 4'd6) : bin[3:0];
            cy[i+1] = adj;
        end
    end

    // Width select on result and carry.
    always_comb begin
        if (byte_mode) begin
            sum  = {{(W-H){1'b0}}, raw_sum[H-1:0]};
            cout = cy[HDIG];
        end else begin
            sum  = raw_sum;
            cout = cy[DIG];
        end
    end
endmodule

// File: rtl/wcalc_shiftlog.sv
// Logical, shift, swap and sign-extend results (no flag generation).
// Assumes single-operand operations take their operand from dst.
module wcalc_shiftlog #(
    parameter int W = 16
) (
    input  wcalc_pkg::calc_op_e op,
    input  logic                byte_mode,
    input  logic [W-1:0]        src,
    input  logic [W-1:0]        dst,
    input  logic                cin,
    output logic [W-1:0]        res
);
    import wcalc_pkg::*;
    localparam int H = W / 2;

    logic [W-1:0] wide;
    logic [W-1:0] hmask;

    // Word-wide result per code; the byte form is masked afterwards.
    always_comb begin
        hmask = byte_mode ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
        case (op)
            OP_AND, OP_BIT: wide = src & dst;
            OP_XOR:         wide = src ^ dst;
            OP_BIC:         wide = ~src & dst;
            OP_BIS:         wide = src | dst;
            OP_RRA:         wide = byte_mode ? {{(W-H){1'b0}}, dst[H-1], dst[H-1:1]}
                                             : {dst[W-1], dst[W-1:1]};
            OP_RRC:         wide = byte_mode ? {{(W-H){1'b0}}, cin, dst[H-1:1]}
                                             : {cin, dst[W-1:1]};
            default:        wide = dst;
        endcase
        case (op)
            OP_SWPB: res = {dst[H-1:0], dst[W-1:H]};
            OP_SXT:  res = {{(W-H){dst[H-1]}}, dst[H-1:0]};
            default: res = wide & hmask;
        endcase
    end
endmodule

// File: rtl/wcalc_alu.sv
// Top of the word/byte ALU: operand conditioning, unit select, flag rules and
// a single output register with a valid strobe (one cycle latency).
// Assumes op/operands are stable only while in_valid is high.
module wcalc_alu #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic             byte_mode,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] dst,
    input  logic             c_in,
    input  logic             z_in,
    input  logic             n_in,
    input  logic             v_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             wr_en,
    output logic             c_out,
    output logic             z_out,
    output logic             n_out,
    output logic             v_out
);
    import wcalc_pkg::*;
    localparam int H = WIDTH / 2;

    calc_op_e        op_e;
    logic            is_sub, eff_byte;
    logic [WIDTH-1:0] add_a, add_sum, bcd_sum, sl_res, nxt_res;
    logic            add_cin, add_c, add_v, bcd_c;
    calc_flags_t     nxt_f;
    logic            nxt_wr, res_zero, res_neg;

    assign op_e = calc_op_e'(op);

    // Condition the adder operands for add or subtract.
    always_comb begin
        is_sub = (op_e == OP_SUB) || (op_e == OP_SUBC) || (op_e == OP_CMP);
        add_a  = is_sub ? ~src : src;
        case (op_e)
            OP_ADD:          add_cin = 1'b0;
            OP_SUB, OP_CMP:  add_cin = 1'b1;
            default:         add_cin = c_in;
        endcase
    end

    wcalc_binadd #(.W(WIDTH)) u_bin (
        .byte_mode (byte_mode),
        .a         (add_a),
        .b         (dst),
        .cin       (add_cin),
        .sum       (add_sum),
        .cout      (add_c),
        .ovf       (add_v)
    );

    wcalc_bcdadd #(.W(WIDTH)) u_bcd (
        .byte_mode (byte_mode),
        .a         (src),
        .b         (dst),
        .cin       (c_in),
        .sum       (bcd_sum),
        .cout      (bcd_c)
    );

    wcalc_shiftlog #(.W(WIDTH)) u_sl (
        .op        (op_e),
        .byte_mode (byte_mode),
        .src       (src),
        .dst       (dst),
        .cin       (c_in),
        .res       (sl_res)
    );

    // Select the result and apply the per-operation flag rules.
    always_comb begin
        case (op_e)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: nxt_res = add_sum;
            OP_DADD:                                  nxt_res = bcd_sum;
            default:                                  nxt_res = sl_res;
        endcase
        eff_byte = byte_mode && (op_e != OP_SWPB) && (op_e != OP_SXT);
        res_zero = eff_byte ? (nxt_res[H-1:0] == '0) : (nxt_res == '0);
        res_neg  = eff_byte ? nxt_res[H-1] : nxt_res[WIDTH-1];
        nxt_wr   = !((op_e == OP_CMP) || (op_e == OP_BIT) || (op_e == OP_NONE));
        nxt_f    = '{c: c_in, z: z_in, n: n_in, v: v_in};
        case (op_e)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP:
                nxt_f = '{c: add_c, z: res_zero, n: res_neg, v: add_v};
            OP_AND, OP_BIT, OP_XOR, OP_SXT:
                nxt_f = '{c: !res_zero, z: res_zero, n: res_neg, v: 1'b0};
            OP_DADD:
                nxt_f = '{c: bcd_c, z: res_zero, n: res_neg, v: 1'b0};
            OP_RRA, OP_RRC:
                nxt_f = '{c: dst[0], z: res_zero, n: res_neg, v: 1'b0};
            default: ;
        endcase
    end

    // Output register: capture on in_valid, strobe valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            c_out     <= 1'b0;
            z_out     <= 1'b0;
            n_out     <= 1'b0;
            v_out     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_res;
                wr_en  <= nxt_wr;
                c_out  <= nxt_f.c;
                z_out  <= nxt_f.z;
                n_out  <= nxt_f.n;
                v_out  <= nxt_f.v;
            end
        end
    end
endmodule

// File: rtl/wcalc_check.sv
// Property checker for wcalc_alu, attached through bind.
// Assumes the top's port names; observes ports only.
module wcalc_check #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic             byte_mode,
    input logic [WIDTH-1:0] src,
    input logic [WIDTH-1:0] dst,
    input logic             c_in,
    input logic             z_in,
    input logic             n_in,
    input logic             v_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             wr_en,
    input logic             c_out,
    input logic             z_out,
    input logic             n_out,
    input logic             v_out
);
    localparam int H = WIDTH / 2;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    p_flag_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && ($past(op) == 4'd4 || $past(op) == 4'd8)) |-> !wr_en);

    p_logic_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && ($past(op) == 4'd5 || $past(op) == 4'd9))
        |-> (c_out == !z_out) && !v_out);

    p_pass_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && ($past(op) == 4'd6 || $past(op) == 4'd7))
        |-> (c_out == $past(c_in)) && (z_out == $past(z_in))
            && (n_out == $past(n_in)) && (v_out == $past(v_in)));

    p_shift_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && ($past(op) == 4'd11 || $past(op) == 4'd12))
        |-> (c_out == $past(dst[0])) && !v_out);

    p_sext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && $past(op) == 4'd14)
        |-> (result[WIDTH-1:H] == {(WIDTH-H){result[H-1]}}));

    p_byte_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && $past(byte_mode) && $past(op) < 4'd13)
        |-> (result[WIDTH-1:H] == '0));

    p_zero_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && $past(op) < 4'd13
         && $past(op) != 4'd6 && $past(op) != 4'd7)
        |-> (z_out == (result == '0)));
endmodule

bind wcalc_alu wcalc_check #(.WIDTH(WIDTH)) u_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .byte_mode(byte_mode), .src(src), .dst(dst), .c_in(c_in),
    .z_in(z_in), .n_in(n_in), .v_in(v_in), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .c_out(c_out), .z_out(z_out),
    .n_out(n_out), .v_out(v_out)
);

// File: tb/wcalc_alu_test.sv
`timescale 1ns/1ps
module wcalc_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] src = '0, dst = '0;
    logic        c_in = 1'b0, z_in = 1'b0, n_in = 1'b0, v_in = 1'b0;
    logic        out_valid, wr_en, c_out, z_out, n_out, v_out;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] res;
        logic        wr, c, z, n, v;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    wcalc_alu #(.WIDTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .byte_mode(byte_mode), .src(src), .dst(dst), .c_in(c_in),
        .z_in(z_in), .n_in(n_in), .v_in(v_in), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .c_out(c_out), .z_out(z_out),
        .n_out(n_out), .v_out(v_out)
    );

    function automatic int unsigned bcd2int(input int unsigned x);
        int unsigned acc = 0, scale = 1;
        for (int i = 0; i < 4; i++) begin
            acc += ((x >> (4*i)) & 15) * scale;
            scale *= 10;
        end
        return acc;
    endfunction

    function automatic int unsigned int2bcd(input int unsigned x);
        int unsigned acc = 0;
        for (int i = 0; i < 4; i++) begin
            acc |= (x % 10) << (4*i);
            x /= 10;
        end
        return acc;
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [3:0] o, input logic bm,
                                   input logic [15:0] s, input logic [15:0] d,
                                   input logic ci, input logic zi,
                                   input logic ni, input logic vi);
        exp_t e;
        int unsigned m, sgn, a, b, r, lim, t;
        bit byt, setnz;
        byt = bm && o != 4'd13 && o != 4'd14;
        m   = byt ? 32'hFF : 32'hFFFF;
        sgn = byt ? 32'h80 : 32'h8000;
        a = s & m;
        b = d & m;
        e.wr = 1; e.c = ci; e.z = zi; e.n = ni; e.v = vi;
        r = b; setnz = 1;
        case (o)
            4'd0, 4'd1: begin
                r = a + b + ((o == 4'd1) ? ci : 0);
                e.c = r > m; r &= m;
                e.v = ((a & sgn) == (b & sgn)) && ((r & sgn) != (a & sgn));
            end
            4'd2, 4'd3, 4'd4: begin
                r = b + (~a & m) + ((o == 4'd3) ? ci : 1);
                e.c = r > m; r &= m;
                e.v = ((a & sgn) != (b & sgn)) && ((r & sgn) != (b & sgn));
                if (o == 4'd4) e.wr = 0;
            end
            4'd5, 4'd8: begin r = a & b; e.c = r != 0; e.v = 0; if (o == 4'd8) e.wr = 0; end
            4'd9: begin r = a ^ b; e.c = r != 0; e.v = 0; end
            4'd6: begin r = ~a & b & m; setnz = 0; end
            4'd7: begin r = a | b; setnz = 0; end
            4'd10: begin
                lim = byt ? 100 : 10000;
                t = bcd2int(a) + bcd2int(b) + ci;
                e.c = t >= lim; r = int2bcd(t % lim); e.v = 0;
            end
            4'd11: begin r = (b >> 1) | (b & sgn); e.c = b[0]; e.v = 0; end
            4'd12: begin r = (b >> 1) | (ci ? sgn : 0); e.c = b[0]; e.v = 0; end
            4'd13: begin r = {16'd0, d[7:0], d[15:8]}; setnz = 0; end
            4'd14: begin r = {16'd0, {8{d[7]}}, d[7:0]}; e.c = r != 0; e.v = 0; end
            default: begin e.wr = 0; setnz = 0; end
        endcase
        if (setnz) begin
            e.z = (r == 0);
            e.n = (r & sgn) != 0;
        end
        e.res = r[15:0];
        return e;
    endfunction

    // Driver: apply one vector at the falling edge and queue its expectation.
    task automatic drive(input logic [3:0] o, input logic bm, input logic [15:0] s,
                         input logic [15:0] d, input logic ci, input logic zi,
                         input logic ni, input logic vi, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; byte_mode = bm; src = s; dst = d;
        c_in = ci; z_in = zi; n_in = ni; v_in = vi;
        in_valid = 1'b1;
        e = model(o, bm, s, d, ci, zi, ni, vi);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare every valid output against the oldest expectation (R2).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t e;
            checks++;
            if (sb_q.size() == 0) begin
                fails++;
                $display("FAIL R2: out_valid=1 actual, expected 0 (no pending item)");
            end else begin
                e = sb_q.pop_front();
                if (result !== e.res || wr_en !== e.wr || c_out !== e.c ||
                    z_out !== e.z || n_out !== e.n || v_out !== e.v) begin
                    fails++;
                    $display("FAIL %s: actual res=%h wr=%b cznv=%b%b%b%b expected res=%h wr=%b cznv=%b%b%b%b",
                             e.tag, result, wr_en, c_out, z_out, n_out, v_out,
                             e.res, e.wr, e.c, e.z, e.n, e.v);
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] rs, rd;
        logic [3:0]  ro;
        // R1: drive inputs during reset; outputs must stay cleared.
        in_valid = 1'b1; op = 4'd7; src = 16'hFFFF; dst = 16'hFFFF; c_in = 1; z_in = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 16'h0 || wr_en !== 1'b0 ||
            {c_out, z_out, n_out, v_out} !== 4'b0) begin
            fails++;
            $display("FAIL R1: actual valid=%b res=%h wr=%b flags=%b expected 0 0000 0 0000",
                     out_valid, result, wr_en, {c_out, z_out, n_out, v_out});
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R3 add / add-with-carry
        drive(4'd0, 0, 16'h0001, 16'h7FFF, 0, 0, 0, 0, "R3");
        drive(4'd0, 0, 16'h0001, 16'hFFFF, 0, 0, 0, 0, "R3");
        drive(4'd1, 0, 16'h0001, 16'h1000, 1, 0, 0, 0, "R3");
        drive(4'd0, 0, 16'h8000, 16'h8000, 0, 0, 0, 0, "R3");
        // R4 subtract / subtract-with-carry
        drive(4'd2, 0, 16'h0005, 16'h0005, 0, 0, 0, 0, "R4");
        drive(4'd2, 0, 16'h0005, 16'h0003, 0, 0, 0, 0, "R4");
        drive(4'd2, 0, 16'h0001, 16'h8000, 0, 0, 0, 0, "R4");
        drive(4'd3, 0, 16'h0003, 16'h0010, 0, 0, 0, 0, "R4");
        // R5 compare and bit-test: flags only
        drive(4'd4, 0, 16'h0009, 16'h0002, 1, 1, 1, 1, "R5");
        drive(4'd8, 0, 16'h00F0, 16'h000F, 0, 0, 0, 0, "R5");
        // R6 AND / XOR carry
        drive(4'd5, 0, 16'hF0F0, 16'h8F00, 0, 1, 0, 1, "R6");
        drive(4'd9, 0, 16'hA5A5, 16'hA5A5, 1, 0, 1, 1, "R6");
        // R7 bit-clear / bit-set flags pass through
        drive(4'd6, 0, 16'h00FF, 16'h1234, 1, 0, 1, 0, "R7");
        drive(4'd7, 0, 16'h8000, 16'h0001, 0, 1, 0, 1, "R7");
        // R8 decimal add
        drive(4'd10, 0, 16'h0001, 16'h0999, 0, 0, 0, 0, "R8");
        drive(4'd10, 0, 16'h0001, 16'h9999, 0, 0, 0, 0, "R8");
        drive(4'd10, 0, 16'h4567, 16'h1234, 1, 0, 0, 0, "R8");
        drive(4'd10, 1, 16'h0001, 16'h3399, 0, 0, 0, 0, "R8");
        // R9 / R10 shifts
        drive(4'd11, 0, 16'h0000, 16'h8001, 0, 0, 0, 1, "R9");
        drive(4'd11, 1, 16'h0000, 16'hFF81, 0, 0, 0, 0, "R9");
        drive(4'd12, 0, 16'h0000, 16'h0002, 1, 0, 0, 0, "R10");
        drive(4'd12, 1, 16'h0000, 16'hAB01, 0, 0, 0, 0, "R10");
        // R11 swap and sign extend ignore byte_mode
        drive(4'd13, 1, 16'h0000, 16'h12AB, 1, 0, 1, 1, "R11");
        drive(4'd14, 1, 16'h0000, 16'h0080, 0, 0, 0, 0, "R11");
        drive(4'd14, 0, 16'h0000, 16'h1200, 1, 0, 0, 1, "R11");
        // R12 byte forms
        drive(4'd1, 1, 16'h3401, 16'h12FF, 1, 0, 0, 0, "R12");
        drive(4'd0, 1, 16'h0001, 16'h007F, 0, 0, 0, 0, "R12");
        drive(4'd2, 1, 16'hFF01, 16'h0000, 0, 0, 0, 0, "R12");
        drive(4'd9, 1, 16'hFFFF, 16'h00FF, 0, 0, 0, 0, "R12");
        // R13 zero with upper bits set in byte mode
        drive(4'd5, 1, 16'hFF00, 16'hFF00, 0, 0, 0, 0, "R13");
        idle(3);
        // R2: gap then back-to-back vectors keep order
        drive(4'd0, 0, 16'h0002, 16'h0003, 0, 0, 0, 0, "R2");
        idle(1);
        drive(4'd0, 0, 16'h0004, 16'h0005, 0, 0, 0, 0, "R2");

        // Random vectors across codes (valid BCD for decimal add).
        for (int k = 0; k < 200; k++) begin
            ro = 4'($urandom_range(0, 14));
            rs = 16'($urandom);
            rd = 16'($urandom);
            if (ro == 4'd10) begin
                for (int j = 0; j < 4; j++) begin
                    rs[4*j +: 4] = 4'($urandom_range(0, 9));
                    rd[4*j +: 4] = 4'($urandom_range(0, 9));
                end
            end
            drive(ro, 1'($urandom), rs, rd, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), (ro < 4'd2) ? "R3" : (ro < 4'd4) ? "R4" : "R12");
        end
        idle(4);

        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R2: actual %0d pending results, expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule